// File: doc/BRIEF.md
# Clock Mode Switch Sequencer

This block changes the system clock mode while external SDRAM is parked in self-refresh, so no memory access can see a clock in transition. It is started with a 4-bit target mode. It then acts as a master on a simple register bus, one access at a time. It masks the global interrupt enable and reads the clock control register. It places the SDRAM in self-refresh and waits until the controller confirms this. It writes the new mode and sets the switch-enable bit, waits a fixed settle period, and brings the SDRAM out of self-refresh. Finally it restores the interrupt enable and signals completion.

While the block is idle, its interrupt-enable output follows the `irq_en_i` request input, one cycle late. During a run that output is held low, whatever the input does. At the end the output takes the value it had when the run started.

Top module: `clk_mode_seq`

## Requirements
- R1: After an active-low asynchronous reset, busy_o and done_o are 0, irq_en_o is 1, and neither bus strobe is asserted.
- R2: A start_i pulse in an idle cycle raises busy_o in the next cycle and drives irq_en_o to 0 in that same cycle. irq_en_o stays 0 for every cycle in which busy_o is 1, whatever irq_en_i does.
- R3: start_i has no effect while busy_o is 1. The run in progress keeps the mode it latched at start, and only one done pulse follows.
- R4: The first bus access of a run is a read of the clock control register at 0xFEFF9A00. Its value is kept for the later enable write.
- R5: Next comes a write of 0x00000001 to the refresh control register at 0xFE000430. After it, the block reads the SDRAM status register at 0xFE000428 again and again until a read returns bit 0 = 1.
- R6: Once self-refresh is confirmed, the block writes the clock mode register at 0xFEFF9A08. Bits 27:24 hold the target mode and all other bits are 0.
- R7: Next the block writes 0xFEFF9A00 with the value read under R4, with bit 31 set and all other bits unchanged.
- R8: The enable write is accepted on one clock edge. The exit write is first presented 256 cycles after the cycle that follows that edge, and no access is made in between. With L wait cycles per access, the two acceptance edges lie 257+L edges apart.
- R9: After the settle wait, the block writes 0x00000000 to 0xFE000430. It then reads 0xFE000428 until a read returns bit 0 = 0.
- R10: Address, write data and strobe stay unchanged while bus_rdy_i is 0. Read data is taken in the cycle bus_rdy_i is 1. Write and read strobes are never both asserted.
- R11: On the clock edge that accepts the final status read, done_o goes high for exactly one cycle. In that same cycle busy_o falls and irq_en_o returns to the value it held just before the run started.
- R12: A run makes exactly 5+N+M bus accesses, where N and M are the numbers of entry and exit polls, and always in the order R4, R5, R6, R7, R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken only when idle |
| mode_i | input | 4 | Target clock mode |
| irq_en_i | input | 1 | Requested interrupt enable, followed while idle |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| irq_en_o | output | 1 | Global interrupt enable |
| bus_addr_o | output | 32 | Register access address |
| bus_wdata_o | output | 32 | Register write data |
| bus_wr_o | output | 1 | Write strobe |
| bus_rd_o | output | 1 | Read strobe |
| bus_rdy_i | input | 1 | Access accepted this cycle |
| bus_rdata_i | input | 32 | Read data, valid with bus_rdy_i |

## Verification
The completion pulse and a new start can land in the same cycle. done_o is high only in an idle cycle, so a start request at that moment must be accepted, and the interrupt state saved for the new run must be the value that was just restored. The bench provokes this by raising start_i in the very cycle it first sees done_o. It then requires busy_o high with irq_en_o low in the next cycle, a complete second access sequence carrying the new mode, and a final restore that returns the original enable value.

// File: rtl/cms_pkg.sv
package cms_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD_CLK,
    ST_WR_SR,
    ST_POLL_IN,
    ST_WR_MODE,
    ST_WR_EN,
    ST_SETTLE,
    ST_WR_SRX,
    ST_POLL_OUT
  } state_t;

  localparam logic [31:0] OFS_SR_CTL   = 32'h30;
  localparam logic [31:0] OFS_SR_STAT  = 32'h28;
  localparam logic [31:0] OFS_CLK_CTL  = 32'h00;
  localparam logic [31:0] OFS_CLK_MODE = 32'h08;

endpackage

// File: rtl/cms_req_gen.sv
module cms_req_gen
  import cms_pkg::*;
#(
  parameter logic [31:0] SDRC_BASE = 32'hFE00_0400,
  parameter logic [31:0] CLKC_BASE = 32'hFEFF_9A00,
  parameter int unsigned MODE_W    = 4,
  parameter int unsigned MODE_LSB  = 24,
  parameter int unsigned EN_BIT    = 31
) (
  input  state_t            state_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [31:0]       clk_val_i,
  output logic [31:0]       addr_o,
  output logic [31:0]       wdata_o,
  output logic              wr_o,
  output logic              rd_o
);

  always_comb begin
    addr_o  = '0;
    wdata_o = '0;
    wr_o    = 1'b0;
    rd_o    = 1'b0;
    case (state_i)
      ST_RD_CLK: begin
        addr_o = CLKC_BASE + OFS_CLK_CTL;
        rd_o   = 1'b1;
      end
      ST_WR_SR: begin
        addr_o  = SDRC_BASE + OFS_SR_CTL;
        wdata_o = 32'h1;
        wr_o    = 1'b1;
      end
      ST_POLL_IN, ST_POLL_OUT: begin
        addr_o = SDRC_BASE + OFS_SR_STAT;
        rd_o   = 1'b1;
      end
      ST_WR_MODE: begin
        addr_o  = CLKC_BASE + OFS_CLK_MODE;
        wdata_o = 32'(mode_i) << MODE_LSB;
        wr_o    = 1'b1;
      end
      ST_WR_EN: begin
        addr_o  = CLKC_BASE + OFS_CLK_CTL;
        wdata_o = clk_val_i | (32'h1 << EN_BIT);
        wr_o    = 1'b1;
      end
      ST_WR_SRX: begin
        addr_o  = SDRC_BASE + OFS_SR_CTL;
        wr_o    = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/cms_settle_timer.sv
module cms_settle_timer #(
  parameter int unsigned CYCLES = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);

  localparam int unsigned CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;

  logic [CNT_W-1:0] cnt_q;

  assign expired_o = run_i && (cnt_q == CNT_W'(CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (!run_i)     cnt_q <= '0;
    else if (!expired_o) cnt_q <= cnt_q + CNT_W'(1);
  end

  // R8: one step per settle cycle, no skips
  a_r8_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && $past(run_i) && !$past(expired_o) |-> cnt_q == $past(cnt_q) + CNT_W'(1));

  // R8: every settle window starts from zero
  a_r8_fresh_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |-> cnt_q == '0);

endmodule

// File: rtl/cms_irq_keeper.sv
module cms_irq_keeper (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_en_i,
  input  logic save_i,
  input  logic restore_i,
  input  logic hold_i,
  output logic irq_en_o
);

  logic irq_q, saved_q;

  assign irq_en_o = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q   <= 1'b1;
      saved_q <= 1'b1;
    end else if (save_i) begin
      saved_q <= irq_q;
      irq_q   <= 1'b0;
    end else if (restore_i) begin
      irq_q   <= saved_q;
    end else if (!hold_i) begin
      irq_q   <= irq_en_i;
    end
  end

  // R2: masked immediately after the save
  a_r2_forced_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_i |=> !irq_en_o);

  // R11: restore brings back the saved value
  a_r11_restore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_i |=> irq_en_o == $past(saved_q));

endmodule

// File: rtl/clk_mode_seq.sv
module clk_mode_seq
  import cms_pkg::*;
#(
  parameter logic [31:0] SDRC_BASE  = 32'hFE00_0400,
  parameter logic [31:0] CLKC_BASE  = 32'hFEFF_9A00,
  parameter int unsigned MODE_W     = 4,
  parameter int unsigned MODE_LSB   = 24,
  parameter int unsigned EN_BIT     = 31,
  parameter int unsigned SETTLE_CYC = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              irq_en_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              irq_en_o,
  output logic [31:0]       bus_addr_o,
  output logic [31:0]       bus_wdata_o,
  output logic              bus_wr_o,
  output logic              bus_rd_o,
  input  logic              bus_rdy_i,
  input  logic [31:0]       bus_rdata_i
);

  localparam logic [31:0] MODE_MASK = ((32'h1 << MODE_W) - 32'h1) << MODE_LSB;

  state_t            state_q;
  logic [MODE_W-1:0] mode_q;
  logic [31:0]       clk_q;
  logic              done_q;
  logic              start_ok, finish, settle_exp;

  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
  assign start_ok = start_i && (state_q == ST_IDLE);
  assign finish   = (state_q == ST_POLL_OUT) && bus_rdy_i && !bus_rdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= '0;
      clk_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= finish;
      case (state_q)
        ST_IDLE:     if (start_ok) begin
                       state_q <= ST_RD_CLK;
                       mode_q  <= mode_i;
                     end
        ST_RD_CLK:   if (bus_rdy_i) begin
                       clk_q   <= bus_rdata_i;
                       state_q <= ST_WR_SR;
                     end
        ST_WR_SR:    if (bus_rdy_i) state_q <= ST_POLL_IN;
        ST_POLL_IN:  if (bus_rdy_i && bus_rdata_i[0]) state_q <= ST_WR_MODE;
        ST_WR_MODE:  if (bus_rdy_i) state_q <= ST_WR_EN;
        ST_WR_EN:    if (bus_rdy_i) state_q <= ST_SETTLE;
        ST_SETTLE:   if (settle_exp) state_q <= ST_WR_SRX;
        ST_WR_SRX:   if (bus_rdy_i) state_q <= ST_POLL_OUT;
        ST_POLL_OUT: if (finish) state_q <= ST_IDLE;
        default:     state_q <= ST_IDLE;
      endcase
    end
  end

  cms_req_gen #(
    .SDRC_BASE(SDRC_BASE), .CLKC_BASE(CLKC_BASE),
    .MODE_W(MODE_W), .MODE_LSB(MODE_LSB), .EN_BIT(EN_BIT)
  ) u_req (
    .state_i  (state_q),
    .mode_i   (mode_q),
    .clk_val_i(clk_q),
    .addr_o   (bus_addr_o),
    .wdata_o  (bus_wdata_o),
    .wr_o     (bus_wr_o),
    .rd_o     (bus_rd_o)
  );

  cms_settle_timer #(.CYCLES(SETTLE_CYC)) u_settle (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (state_q == ST_SETTLE),
    .expired_o(settle_exp)
  );

  cms_irq_keeper u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .irq_en_i (irq_en_i),
    .save_i   (start_ok),
    .restore_i(finish),
    .hold_i   (busy_o),
    .irq_en_o (irq_en_o)
  );

  // R2: interrupts masked for the whole run
  a_r2_irq_off_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !irq_en_o);

  // R3: start while busy leaves the latched mode alone
  a_r3_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> mode_q == $past(mode_q));

  // R6: mode write touches only the mode field
  a_r6_mode_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wr_o && bus_addr_o == CLKC_BASE + OFS_CLK_MODE |-> (bus_wdata_o & ~MODE_MASK) == '0);

  // R7: control write always carries the enable bit
  a_r7_enable_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wr_o && bus_addr_o == CLKC_BASE + OFS_CLK_CTL |-> bus_wdata_o[EN_BIT]);

  // R10: request held until accepted
  a_r10_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_o || bus_rd_o) && !bus_rdy_i |=>
      (bus_wr_o || bus_rd_o) && $stable(bus_addr_o) && $stable(bus_wdata_o) && $stable(bus_wr_o));

  // R10: one kind of access at a time
  a_r10_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_wr_o && bus_rd_o));

  // R11: done is a single idle-cycle pulse
  a_r11_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

endmodule

// File: tb/clk_mode_seq_test.sv
`timescale 1ns/1ps
module clk_mode_seq_test;

  typedef struct packed {
    logic [3:0]  mode;
    logic [31:0] clk;
    logic        irq;
    logic [3:0]  pin;
    logic [3:0]  pout;
    logic [3:0]  lat;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{4'h3, 32'h0012_3456, 1'b1, 4'd1, 4'd1, 4'd0},
    '{4'hA, 32'h7F00_00C5, 1'b0, 4'd3, 4'd2, 4'd1},
    '{4'hF, 32'h8000_0001, 1'b1, 4'd4, 4'd5, 4'd2},
    '{4'h0, 32'h5A5A_A5A5, 1'b0, 4'd2, 4'd1, 4'd3}
  };

  localparam logic [31:0] A_SRCTL = 32'hFE00_0430;
  localparam logic [31:0] A_STAT  = 32'hFE00_0428;
  localparam logic [31:0] A_CCTL  = 32'hFEFF_9A00;
  localparam logic [31:0] A_MODE  = 32'hFEFF_9A08;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic        irq_en_in = 1'b1;
  logic        busy, done, irq_en;
  logic [31:0] addr, wdata;
  logic        wr, rd;
  logic        rdy = 1'b0;
  logic [31:0] rdata = '0;

  int checks = 0, errs = 0;
  int lat = 0, pin = 1, pout = 1;
  logic [31:0] clk_val = '0;

  logic [31:0] log_addr [256];
  logic [31:0] log_data [256];
  logic        log_wr   [256];
  int          log_cyc  [256];
  int          n_log = 0, cyc = 0, hold_viol = 0, irq_viol = 0;

  always #10 clk = ~clk;

  clk_mode_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .irq_en_i(irq_en_in),
    .busy_o(busy), .done_o(done), .irq_en_o(irq_en),
    .bus_addr_o(addr), .bus_wdata_o(wdata), .bus_wr_o(wr), .bus_rd_o(rd),
    .bus_rdy_i(rdy), .bus_rdata_i(rdata)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // register slave: L wait cycles per access, then ready for one cycle
  int          wcnt = 0, pcnt = 0;
  logic        sr_req = 1'b0, pend = 1'b0;
  logic [31:0] paddr = '0, pdata = '0;

  always @(negedge clk) begin
    if (!rst_n) begin
      rdy = 1'b0; wcnt = 0; sr_req = 1'b0; pcnt = 0; pend = 1'b0;
    end else begin
      if (pend && (!(wr || rd) || addr != paddr || wdata != pdata)) hold_viol++;
      if (wr || rd) begin
        if (wcnt == lat) begin
          rdy = 1'b1; wcnt = 0;
          if (addr == A_CCTL) rdata = clk_val;
          else if (addr == A_STAT)
            rdata = {31'b0, sr_req ? (pcnt >= pin - 1) : (pcnt < pout - 1)};
          else rdata = '0;
          if (n_log < 256) begin
            log_addr[n_log] = addr; log_data[n_log] = wdata;
            log_wr[n_log] = wr; log_cyc[n_log] = cyc;
          end
          n_log++;
          if (rd && addr == A_STAT) pcnt++;
          if (wr && addr == A_SRCTL) begin sr_req = wdata[0]; pcnt = 0; end
        end else begin
          rdy = 1'b0; wcnt++;
        end
      end else begin
        rdy = 1'b0; wcnt = 0;
      end
      pend = (wr || rd) && !rdy;
      paddr = addr; pdata = wdata;
    end
  end

  task automatic chk(input string req, input bit ok, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic void exp_entry(input int i, input int p, input logic [3:0] m,
                                    input logic [31:0] c, output logic [31:0] a,
                                    output logic w, output logic [31:0] d, output string tg);
    d = '0;
    if (i == 0)          begin a = A_CCTL;  w = 1'b0; tg = "R4"; end
    else if (i == 1)     begin a = A_SRCTL; w = 1'b1; d = 32'h1; tg = "R5"; end
    else if (i < 2 + p)  begin a = A_STAT;  w = 1'b0; tg = "R5"; end
    else if (i == 2 + p) begin a = A_MODE;  w = 1'b1; d = {4'b0, m, 24'b0}; tg = "R6"; end
    else if (i == 3 + p) begin a = A_CCTL;  w = 1'b1; d = c | 32'h8000_0000; tg = "R7"; end
    else if (i == 4 + p) begin a = A_SRCTL; w = 1'b1; tg = "R9"; end
    else                 begin a = A_STAT;  w = 1'b0; tg = "R9"; end
  endfunction

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int k = 0; k < 3000 && !ok; k++) begin
      @(negedge clk);
      if (busy && irq_en) irq_viol++;
      if (done) ok = 1'b1;
    end
  endtask

  task automatic check_log(input int base, input logic [3:0] m, input logic [31:0] c);
    int n;
    logic [31:0] ea, ed;
    logic ew;
    string tg;
    n = 5 + pin + pout;
    chk("R12", (n_log - base) == n, "access count", 32'(n_log - base), 32'(n));
    for (int i = 0; i < n; i++) begin
      exp_entry(i, pin, m, c, ea, ew, ed, tg);
      chk(tg, log_addr[base+i] == ea && log_wr[base+i] == ew && (!ew || log_data[base+i] == ed),
          $sformatf("access %0d addr/data", i), log_wr[base+i] ? log_data[base+i] : log_addr[base+i],
          ew ? ed : ea);
    end
    chk("R8", (log_cyc[base+4+pin] - log_cyc[base+3+pin]) == 257 + lat, "settle gap",
        32'(log_cyc[base+4+pin] - log_cyc[base+3+pin]), 32'(257 + lat));
  endtask

  task automatic setup(input vec_t v);
    lat = int'(v.lat); pin = int'(v.pin); pout = int'(v.pout); clk_val = v.clk;
    irq_en_in = v.irq;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_vec(input vec_t v, input bit poke);
    int base, hb, ib;
    bit ok;
    setup(v);
    base = n_log; hb = hold_viol; ib = irq_viol;
    start = 1'b1; mode = v.mode;
    @(negedge clk);
    start = 1'b0;
    chk("R2", busy && !irq_en, "busy/irq after start", {30'b0, busy, irq_en}, 32'h2);
    irq_en_in = ~v.irq;
    if (poke) begin
      repeat (4) @(negedge clk);
      chk("R3", busy, "busy at poke", {31'b0, busy}, 32'h1);
      start = 1'b1; mode = ~v.mode;
      @(negedge clk);
      start = 1'b0;
    end
    wait_done(ok);
    chk("R11", ok, "done seen", {31'b0, ok}, 32'h1);
    chk("R11", irq_en == v.irq && !busy, "irq/busy at done", {30'b0, busy, irq_en}, {31'b0, v.irq});
    @(negedge clk);
    chk("R11", !done, "done width", {31'b0, done}, 32'h0);
    repeat (3) @(negedge clk);
    chk("R3", !busy && !done, "no extra run", {30'b0, busy, done}, 32'h0);
    chk("R2", irq_viol == ib, "irq low while busy", 32'(irq_viol - ib), 32'h0);
    chk("R10", hold_viol == hb, "request held", 32'(hold_viol - hb), 32'h0);
    check_log(base, v.mode, v.clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    bit ok;
    int base2;
    repeat (2) @(negedge clk);
    chk("R1", !busy && !done && irq_en && !wr && !rd, "reset state",
        {28'b0, busy, done, wr, rd}, 32'h0);
    chk("R1", irq_en, "irq after reset", {31'b0, irq_en}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 4; i++) run_vec(VECS[i], i == 2);

    // start in the done cycle
    setup(VECS[1]);
    start = 1'b1; mode = VECS[1].mode;
    @(negedge clk);
    start = 1'b0;
    wait_done(ok);
    chk("R11", ok, "first done", {31'b0, ok}, 32'h1);
    start = 1'b1; mode = 4'h9;
    base2 = n_log;
    @(negedge clk);
    start = 1'b0;
    chk("R2", busy && !irq_en && !done, "start on done cycle", {29'b0, busy, irq_en, done}, 32'h4);
    wait_done(ok);
    chk("R11", ok && irq_en == VECS[1].irq, "restore after chained run",
        {31'b0, irq_en}, {31'b0, VECS[1].irq});
    check_log(base2, 4'h9, VECS[1].clk);

    // reset mid-run
    setup(VECS[2]);
    start = 1'b1; mode = 4'h5;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", !busy && !done && irq_en && !wr && !rd, "reset mid-run",
        {28'b0, busy, done, wr, rd}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", !busy && !wr && !rd, "idle after reset", {29'b0, busy, wr, rd}, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

endmodule